// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Exact Recency Replacement

This block is a small, fully associative cache of recent virtual-to-physical page translations. It sits beside a page-table walker. Each lookup searches every entry at once. The search key is the current address-space identifier placed above the virtual page number. On a hit, the block returns the physical frame number combinationally in the same cycle and raises a cancel signal, so the walker abandons the table walk it started in parallel. On a miss, the walker completes and presents its result on the refill port. The block installs that result and, when no slot is free, evicts the entry that was used least recently.

Because every entry carries its identifier, a context switch only changes the identifier input and the cache keeps its contents. A flush input invalidates the whole cache for cases where that is not wanted. Recency is kept exactly: each entry holds an age rank that is updated in the same cycle as a hit or a refill.

Top module: `tlb_asid_lru`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses.
- R2: A lookup with `lk_valid` high whose key {`cur_asid`, `lk_vpn`} equals a valid entry's key drives `hit` and `walk_cancel` high and `frame` to that entry's frame in the same cycle.
- R3: A lookup that misses drives `hit` low, `walk_cancel` low and `frame` to zero.
- R4: A refill with `fill_valid` high installs key {`fill_asid`, `fill_vpn`} with `fill_frame` at the next clock edge. Later lookups of that key hit.
- R5: Entries with the same virtual page number but different identifiers are separate. Each returns its own frame.
- R6: A refill whose key is not present goes to the lowest-numbered invalid entry if one exists. No valid entry is evicted while a slot is free.
- R7: When all entries are valid, a refill of a new key evicts the entry that was least recently hit or filled.
- R8: A refill whose key is already present overwrites that entry's frame in place. It never creates a second copy of the key.
- R9: A refill and a lookup in the same cycle: the refill is applied first. A lookup of the refilled key hits in that cycle with the new frame, and the lookup then counts as the more recent use.
- R10: `flush` invalidates every entry at the next edge and resets all ages. In the flush cycle, lookups miss and a refill is discarded.
- R11: With `lk_valid` low, `hit` and `walk_cancel` stay low and no recency state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| cur_asid | input | ASID_W | Current address-space identifier |
| fill_valid | input | 1 | Refill from the table walker |
| fill_asid | input | ASID_W | Identifier of the refilled translation |
| fill_vpn | input | VPN_W | Page number of the refilled translation |
| fill_frame | input | FRAME_W | Frame number of the refilled translation |
| hit | output | 1 | Lookup hit |
| frame | output | FRAME_W | Frame number on hit, zero otherwise |
| walk_cancel | output | 1 | Abort the parallel table walk |

## Verification
Directed sequences cover several cases. Filling eight distinct keys and then touching one shows whether the least recent entry is chosen for eviction, as opposed to the lowest index or the oldest fill. The same page under two identifiers shows whether the identifier takes part in the key. A fill and a lookup of the same key in one cycle shows whether the refill is applied before the search. A flush cycle with a concurrent fill shows whether flush takes priority. Random traffic over a small key space, with frequent refills, re-fills of existing keys and rare flushes, keeps the cache full and churning. A recency-stamp model in the bench predicts every hit and frame under that traffic.

// File: rtl/tlb_asid_pkg.sv
package tlb_asid_pkg;
    localparam int unsigned DEF_ENTRIES = 8;
    localparam int unsigned DEF_ASID_W  = 8;
    localparam int unsigned DEF_VPN_W   = 20;
    localparam int unsigned DEF_FRAME_W = 24;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int unsigned N     = 8,
    parameter int unsigned KEY_W = 28,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]        key,
    output logic                    any,
    output logic [N-1:0]            onehot,
    output logic [IDX_W-1:0]        idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign onehot[g] = valid[g] && (keys[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IDX_W'(i);
        end
    end

    assign any = |onehot;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int unsigned N     = 8,
    parameter int unsigned AGE_W = 3,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][AGE_W-1:0] age,
    output logic [IDX_W-1:0]        idx
);
    logic             free_found;
    logic [AGE_W-1:0] best;

    always_comb begin
        free_found = 1'b0;
        idx        = '0;
        best       = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                idx        = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            best = age[0];
            for (int i = 1; i < N; i++) begin
                if (age[i] > best) begin
                    best = age[i];
                    idx  = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/tlb_asid_lru.sv
module tlb_asid_lru
    import tlb_asid_pkg::*;
#(
    parameter int unsigned N_ENTRIES = DEF_ENTRIES,
    parameter int unsigned ASID_W    = DEF_ASID_W,
    parameter int unsigned VPN_W     = DEF_VPN_W,
    parameter int unsigned FRAME_W   = DEF_FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               lk_valid,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  cur_asid,
    input  logic               fill_valid,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [FRAME_W-1:0] fill_frame,
    output logic               hit,
    output logic [FRAME_W-1:0] frame,
    output logic               walk_cancel
);
    localparam int unsigned KEY_W = ASID_W + VPN_W;
    localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam int unsigned AGE_W = IDX_W;

    typedef struct packed {
        logic [N_ENTRIES-1:0]              valid;
        logic [N_ENTRIES-1:0][KEY_W-1:0]   key;
        logic [N_ENTRIES-1:0][FRAME_W-1:0] frame;
        logic [N_ENTRIES-1:0][AGE_W-1:0]   age;
    } tlb_state_t;

    tlb_state_t state_q, mid_s, state_d;

    logic [KEY_W-1:0]     fill_key, lk_key;
    logic                 fill_hit, lk_match, lk_hit;
    logic [N_ENTRIES-1:0] fill_onehot, lk_onehot;
    logic [IDX_W-1:0]     fill_idx, vic_idx, tgt_idx, lk_idx;

    // Make entry k most recent: every valid entry younger than k ages by one.
    function automatic tlb_state_t touch(tlb_state_t s, logic [IDX_W-1:0] k,
                                         logic [AGE_W-1:0] old_age);
        tlb_state_t r = s;
        for (int j = 0; j < N_ENTRIES; j++) begin
            if (IDX_W'(j) != k && s.valid[j] && s.age[j] < old_age)
                r.age[j] = s.age[j] + AGE_W'(1);
        end
        r.age[k] = '0;
        return r;
    endfunction

    assign fill_key = {fill_asid, fill_vpn};
    assign lk_key   = {cur_asid, lk_vpn};

    tlb_match #(.N(N_ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_fill_match (
        .valid (state_q.valid), .keys(state_q.key), .key(fill_key),
        .any   (fill_hit), .onehot(fill_onehot), .idx(fill_idx)
    );

    tlb_victim #(.N(N_ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_victim (
        .valid (state_q.valid), .age(state_q.age), .idx(vic_idx)
    );

    assign tgt_idx = fill_hit ? fill_idx : vic_idx;

    // Stage 1: refill applied before the search.
    always_comb begin
        mid_s = state_q;
        if (fill_valid && !flush) begin
            mid_s = touch(state_q, tgt_idx,
                          state_q.valid[tgt_idx] ? state_q.age[tgt_idx] : '1);
            mid_s.valid[tgt_idx] = 1'b1;
            mid_s.key[tgt_idx]   = fill_key;
            mid_s.frame[tgt_idx] = fill_frame;
        end
    end

    tlb_match #(.N(N_ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_lk_match (
        .valid (mid_s.valid), .keys(mid_s.key), .key(lk_key),
        .any   (lk_match), .onehot(lk_onehot), .idx(lk_idx)
    );

    assign lk_hit = lk_valid && !flush && lk_match;

    // Stage 2: recency update of the hit, flush last.
    always_comb begin
        state_d = mid_s;
        if (flush) begin
            state_d.valid = '0;
            for (int i = 0; i < N_ENTRIES; i++) state_d.age[i] = '1;
        end else if (lk_hit) begin
            state_d = touch(mid_s, lk_idx, mid_s.age[lk_idx]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.valid <= '0;
            state_q.key   <= '0;
            state_q.frame <= '0;
            for (int i = 0; i < N_ENTRIES; i++) state_q.age[i] <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign hit         = lk_hit;
    assign walk_cancel = lk_hit;
    assign frame       = lk_hit ? mid_s.frame[lk_idx] : '0;

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q.valid == '0));

    // R8
    no_dup_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_onehot));

    // R6
    fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush && !fill_hit && !(&state_q.valid))
        |=> ($countones(state_q.valid) == $past($countones(state_q.valid)) + 1));

    // R7
    hit_recent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |=> (state_q.age[$past(lk_idx)] == '0));

    // R7
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (state_q.valid[i])
                    age_rank_chk: assert (int'(state_q.age[i]) < $countones(state_q.valid));
            end
        end
    end
endmodule

// File: tb/tlb_asid_lru_tb_top.sv
module tlb_asid_lru_tb_top;
    localparam int N = 8;

    logic        clk = 0, rst_n = 0, flush = 0, lk_valid = 0, fill_valid = 0;
    logic [19:0] lk_vpn = 0, fill_vpn = 0;
    logic [7:0]  cur_asid = 0, fill_asid = 0;
    logic [23:0] fill_frame = 0;
    logic        hit, walk_cancel;
    logic [23:0] frame;

    int checks = 0, fails = 0, tnow = 0;
    bit done = 0;

    bit          m_valid [N];
    logic [27:0] m_key   [N];
    logic [23:0] m_frame [N];
    int          m_stamp [N];

    always #2 clk = ~clk;

    tlb_asid_lru dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
        .lk_vpn(lk_vpn), .cur_asid(cur_asid), .fill_valid(fill_valid),
        .fill_asid(fill_asid), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
        .hit(hit), .frame(frame), .walk_cancel(walk_cancel)
    );

    function automatic int find_key(logic [27:0] k);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_key[i] == k) return i;
        return -1;
    endfunction

    function automatic int pick_slot(logic [27:0] k);
        int s = find_key(k);
        int oldest;
        if (s >= 0) return s;
        for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
        oldest = 0;
        for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[oldest]) oldest = i;
        return oldest;
    endfunction

    task automatic check1(string tag, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(bit f, bit lv, logic [7:0] a, logic [19:0] v,
                        bit fv, logic [7:0] fa, logic [19:0] fvp,
                        logic [23:0] ff, string tag);
        int s;
        bit e_hit;
        logic [23:0] e_frame;
        flush = f; lk_valid = lv; cur_asid = a; lk_vpn = v;
        fill_valid = fv; fill_asid = fa; fill_vpn = fvp; fill_frame = ff;
        e_hit = 0; e_frame = 0;
        if (!f && fv) begin
            s = pick_slot({fa, fvp});
            tnow++;
            m_valid[s] = 1; m_key[s] = {fa, fvp}; m_frame[s] = ff; m_stamp[s] = tnow;
        end
        if (!f && lv) begin
            s = find_key({a, v});
            if (s >= 0) begin
                e_hit = 1; e_frame = m_frame[s];
                tnow++; m_stamp[s] = tnow;
            end
        end
        if (f) for (int i = 0; i < N; i++) m_valid[i] = 0;
        @(negedge clk);
        check1({tag, " hit"}, 24'(hit), 24'(e_hit));
        check1({tag, " walk_cancel"}, 24'(walk_cancel), 24'(e_hit));
        check1({tag, " frame"}, frame, e_frame);
        @(posedge clk); #1;
    endtask

    task automatic look(logic [7:0] a, logic [19:0] v, string tag);
        step(0, 1, a, v, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(logic [7:0] a, logic [19:0] v, logic [23:0] fr, string tag);
        step(0, 0, 0, 0, 1, a, v, fr, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_stamp[i] = 0; m_key[i] = 0; m_frame[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        look(8'd1, 20'd5, "R1 lookup after reset");
        fill(8'd1, 20'd5, 24'hA0A0A0, "R4 fill");
        step(0, 0, 8'd1, 20'd5, 0, 0, 0, 0, "R11 idle lookup");
        look(8'd1, 20'd5, "R2 hit after fill");
        look(8'd1, 20'd6, "R3 miss other page");
        fill(8'd2, 20'd5, 24'hB0B0B0, "R5 fill other asid");
        look(8'd1, 20'd5, "R5 asid1 frame");
        look(8'd2, 20'd5, "R5 asid2 frame");
        fill(8'd1, 20'd5, 24'hC1C1C1, "R8 refill existing");
        look(8'd1, 20'd5, "R8 updated frame");
        step(1, 1, 8'd1, 20'd5, 1, 8'd3, 20'd9, 24'h111111, "R10 flush cycle");
        look(8'd1, 20'd5, "R10 after flush");
        look(8'd3, 20'd9, "R10 fill dropped");

        for (int i = 0; i < N; i++) fill(8'd3, 20'(100 + i), 24'(16'hF000 + i), "R6 fill free");
        for (int i = 0; i < N; i++) look(8'd3, 20'(100 + i), "R6 all retained");
        look(8'd3, 20'd100, "R7 refresh");
        fill(8'd3, 20'd108, 24'h00BEEF, "R7 fill full");
        look(8'd3, 20'd101, "R7 lru evicted");
        look(8'd3, 20'd100, "R7 refreshed kept");
        look(8'd3, 20'd108, "R7 new entry");
        step(0, 1, 8'd4, 20'd200, 1, 8'd4, 20'd200, 24'h0C0FFE, "R9 fill and lookup");

        for (int n = 0; n < 3000; n++) begin
            bit f, lv, fv;
            f  = ($urandom % 100) == 0;
            lv = ($urandom % 10) < 7;
            fv = ($urandom % 10) < 3;
            step(f, lv, 8'($urandom % 3), 20'($urandom % 12),
                 fv, 8'($urandom % 3), 20'($urandom % 12), 24'($urandom),
                 "R2/R7 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule